// File: doc/BRIEF.md
# Descriptor Ring Queue Manager

This block runs the hardware side of a circular descriptor queue that software and an execution engine share. Software sets the ring length and entry-size mode through a small register port. It hands over work by writing a count of newly posted entries. It takes back finished entries by writing a release count. The block tracks four contiguous regions of the ring: free, posted, in flight and done-awaiting-release. It tracks them with counters and two pointers, so software never writes a raw pointer.

When the block is running and posted work exists, it offers one ring index at a time to a downstream execution unit over a valid/ready handshake. The unit returns a single-cycle completion pulse for each entry, in issue order. The block keeps a packed status word with the done count and the index of the oldest done entry. It raises an interrupt when the done count reaches a programmable threshold, or when a completing entry asks for an interrupt. An add count or release count that cannot be honoured sets a sticky error bit.

Top module: `ring_queue_mgr`

## Requirements
- R1: After reset the block is stopped, `irq` is low and `desc_valid` is low. The done word (0x00C) reads 0, the size register (0x008) reads 16, the entry-mode register (0x100) reads 7 and the stop register (0x800) reads 1.
- R2: Writing N to the add register (0x808) posts N entries after the last posted one. While running, the block issues them one per valid/ready handshake in ring order on `desc_idx`, wrapping from size-1 to 0.
- R3: Writing 0 to the stop register (0x800) makes the block run. Writing any nonzero value stops it. While stopped, `desc_valid` stays low even with posted work.
- R4: An add count larger than the free space is cut to the free space. The free space is the size minus the posted, in-flight and done entries. A cut add sets sticky bit 0 of the error register (0x020).
- R5: Each accepted completion pulse raises the done count by one. The done word holds the count in bits [14:0] and the oldest done index in bits [29:16].
- R6: Writing N to the release register (0x804), with N not above the done count, lowers the count by N and advances the oldest index by N modulo the size. A larger N changes nothing and sets sticky bit 1 of the error register. Writing 1 to an error bit clears it.
- R7: `irq` is set when the next done count is nonzero and at least the threshold, or when a completion arrives with `exec_irq_req` high. `irq` is cleared when a release leaves the count below the threshold. `irq` is never high with a done count of 0.
- R8: The entry-mode register accepts only 1 (short entries, up to 16384 entries) or 7 (long entries, up to 4096 entries). Size writes are clamped to the range 1 to the mode limit. Size and mode writes take effect only while the ring is empty, and they reset both pointers to 0.
- R9: The threshold register (0x018) keeps the low 15 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| desc_valid | output | 1 | An entry is offered for execution |
| desc_ready | input | 1 | The execution unit takes the offered entry |
| desc_idx | output | 14 | Ring index of the offered entry |
| exec_done | input | 1 | One-cycle pulse: oldest in-flight entry finished |
| exec_irq_req | input | 1 | The finishing entry requests an interrupt |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take three things for granted about the inputs. The execution unit finishes entries in the order they were issued. It pulses `exec_done` only while an entry is in flight. Software writes one register per cycle. The stimulus keeps to this by never having more than one entry in flight. It raises `exec_done` only on the cycle after a handshake has completed, and it sequences every register access through single-cycle write tasks. Illegal add and release counts are still driven on purpose, because the block must absorb them.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int ADDR_W = 12;
  localparam int DONE_IDX_LSB = 16;

  localparam logic [ADDR_W-1:0] OFF_SIZE = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_DONE = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_THR  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_ERR  = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_MODE = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_STOP = 12'h800;
  localparam logic [ADDR_W-1:0] OFF_REL  = 12'h804;
  localparam logic [ADDR_W-1:0] OFF_ADD  = 12'h808;

  localparam logic [31:0] CODE_SHORT = 32'd1;
  localparam logic [31:0] CODE_LONG  = 32'd7;

  typedef enum logic {ENT_SHORT, ENT_LONG} ent_mode_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_pkg::*;
#(
  parameter int IDX_W     = 14,
  parameter int BIG_IDX_W = 12,
  parameter int THR_W     = 15,
  parameter int RST_SIZE  = 16,
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              ring_empty,
  input  logic              ovf_set,
  input  logic              unf_set,
  input  logic [CNT_W-1:0]  done_cnt,
  input  logic [IDX_W-1:0]  oldest_idx,
  output logic [CNT_W-1:0]  size_eff,
  output logic [THR_W-1:0]  thr,
  output logic              run,
  output logic              cfg_load,
  output logic [31:0]       reg_rdata
);
  localparam logic [31:0] SHORT_MAX = 32'(2 ** IDX_W);
  localparam logic [31:0] LONG_MAX  = 32'(2 ** BIG_IDX_W);

  logic [CNT_W-1:0] size_q, size_n;
  ent_mode_e        mode_q, mode_n;
  logic [THR_W-1:0] thr_q, thr_n;
  logic             stop_q, stop_n;
  logic             ovf_q, ovf_n, unf_q, unf_n;
  logic [31:0]      mode_max;
  logic             wr_size, wr_mode, wr_thr, wr_stop, wr_err;

  always_comb begin
    wr_size  = reg_we && (reg_addr == OFF_SIZE);
    wr_mode  = reg_we && (reg_addr == OFF_MODE);
    wr_thr   = reg_we && (reg_addr == OFF_THR);
    wr_stop  = reg_we && (reg_addr == OFF_STOP);
    wr_err   = reg_we && (reg_addr == OFF_ERR);
    mode_max = (mode_q == ENT_SHORT) ? SHORT_MAX : LONG_MAX;

    size_n = size_q;
    if (wr_size && ring_empty) begin
      if (reg_wdata == 32'd0)          size_n = CNT_W'(1);
      else if (reg_wdata > mode_max)   size_n = CNT_W'(mode_max);
      else                             size_n = CNT_W'(reg_wdata);
    end

    mode_n = mode_q;
    if (wr_mode && ring_empty) begin
      if (reg_wdata == CODE_SHORT)     mode_n = ENT_SHORT;
      else if (reg_wdata == CODE_LONG) mode_n = ENT_LONG;
    end

    thr_n  = wr_thr  ? THR_W'(reg_wdata) : thr_q;
    stop_n = wr_stop ? (reg_wdata != 32'd0) : stop_q;
    ovf_n  = ovf_set | (ovf_q & ~(wr_err & reg_wdata[0]));
    unf_n  = unf_set | (unf_q & ~(wr_err & reg_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= CNT_W'(RST_SIZE);
      mode_q <= ENT_LONG;
      thr_q  <= '1;
      stop_q <= 1'b1;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      size_q <= size_n;
      mode_q <= mode_n;
      thr_q  <= thr_n;
      stop_q <= stop_n;
      ovf_q  <= ovf_n;
      unf_q  <= unf_n;
    end
  end

  always_comb begin
    size_eff = (32'(size_q) > mode_max) ? CNT_W'(mode_max) : size_q;
    thr      = thr_q;
    run      = ~stop_q;
    cfg_load = (wr_size || wr_mode) && ring_empty;
    case (reg_addr)
      OFF_SIZE: reg_rdata = 32'(size_q);
      OFF_DONE: reg_rdata = 32'(done_cnt) | (32'(oldest_idx) << DONE_IDX_LSB);
      OFF_THR:  reg_rdata = 32'(thr_q);
      OFF_ERR:  reg_rdata = {30'd0, unf_q, ovf_q};
      OFF_MODE: reg_rdata = (mode_q == ENT_SHORT) ? CODE_SHORT : CODE_LONG;
      OFF_STOP: reg_rdata = {31'd0, stop_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  // R9: threshold keeps only its low bits
  assert_thr_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> (32'(thr_q) == ($past(reg_wdata) & 32'(2 ** THR_W - 1))));
endmodule

// File: rtl/ring_tracker.sv
module ring_tracker #(
  parameter int IDX_W  = 14,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] size_eff,
  input  logic             run,
  input  logic             cfg_load,
  input  logic             add_we,
  input  logic             rel_we,
  input  logic [31:0]      wdata,
  input  logic             desc_ready,
  input  logic             exec_done,
  output logic             desc_valid,
  output logic [IDX_W-1:0] desc_idx,
  output logic [CNT_W-1:0] done_cnt,
  output logic [CNT_W-1:0] done_nxt,
  output logic [IDX_W-1:0] oldest_idx,
  output logic             ring_empty,
  output logic             ovf_set,
  output logic             unf_set,
  output logic             comp,
  output logic             rel_acc
);
  logic [CNT_W-1:0] posted_q, posted_n, infl_q, infl_n, done_q;
  logic [IDX_W-1:0] iss_q, iss_n, rel_q, rel_n;
  logic [CNT_W:0]   used, free_sp, rel_sum;
  logic [CNT_W-1:0] iss_inc, add_amt, rel_amt;
  logic             fire;

  always_comb begin
    used    = {1'b0, posted_q} + {1'b0, infl_q} + {1'b0, done_q};
    free_sp = {1'b0, size_eff} - used;
    fire    = desc_valid && desc_ready;
    comp    = exec_done && (infl_q != '0);

    ovf_set = 1'b0;
    add_amt = '0;
    if (add_we) begin
      if (wdata > 32'(free_sp)) begin
        add_amt = CNT_W'(free_sp);
        ovf_set = 1'b1;
      end else begin
        add_amt = CNT_W'(wdata);
      end
    end

    rel_acc = rel_we && (wdata <= 32'(done_q));
    unf_set = rel_we && !rel_acc;
    rel_amt = rel_acc ? CNT_W'(wdata) : '0;

    posted_n = posted_q + add_amt - CNT_W'(fire);
    infl_n   = infl_q + CNT_W'(fire) - CNT_W'(comp);
    done_nxt = done_q + CNT_W'(comp) - rel_amt;

    iss_inc = {1'b0, iss_q} + CNT_W'(1);
    rel_sum = {2'b00, rel_q} + {1'b0, rel_amt};
    iss_n = iss_q;
    if (fire) iss_n = (iss_inc >= size_eff) ? '0 : IDX_W'(iss_inc);
    rel_n = IDX_W'((rel_sum >= {1'b0, size_eff}) ? rel_sum - {1'b0, size_eff} : rel_sum);
    if (cfg_load) begin
      iss_n = '0;
      rel_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posted_q <= '0;
      infl_q   <= '0;
      done_q   <= '0;
      iss_q    <= '0;
      rel_q    <= '0;
    end else begin
      posted_q <= posted_n;
      infl_q   <= infl_n;
      done_q   <= done_nxt;
      iss_q    <= iss_n;
      rel_q    <= rel_n;
    end
  end

  always_comb begin
    desc_valid = run && (posted_q != '0);
    desc_idx   = iss_q;
    done_cnt   = done_q;
    oldest_idx = rel_q;
    ring_empty = (used == '0);
  end

  // R4: the occupied regions never exceed the ring
  assert_capacity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(posted_q) + 32'(infl_q) + 32'(done_q) <= 32'(size_eff));
  // R2: an offered index lies inside the ring
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (32'(desc_idx) < 32'(size_eff)));
  // R2: a handshake moves the issue point on
  assert_issue_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready && (size_eff > CNT_W'(1))) |=> (desc_idx != $past(desc_idx)));
  // R5: the done count climbs by at most one per cycle
  assert_done_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(done_q) <= 32'($past(done_q)) + 32'd1);
  // R6: an oversized release never lowers the count
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_we && (wdata > 32'(done_q))) |=> (done_q >= $past(done_q)));
endmodule

// File: rtl/ring_irq.sv
module ring_irq #(
  parameter int CNT_W = 15,
  parameter int THR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] done_nxt,
  input  logic [THR_W-1:0] thr,
  input  logic             comp_req,
  input  logic             rel_acc,
  output logic             irq
);
  logic irq_q, irq_n;

  always_comb begin
    irq_n = irq_q;
    if (done_nxt == '0)                   irq_n = 1'b0;
    else if (32'(done_nxt) >= 32'(thr))   irq_n = 1'b1;
    else if (comp_req)                    irq_n = 1'b1;
    else if (rel_acc)                     irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq = irq_q;

  // R7: a release that leaves the count under the threshold drops the line
  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_acc && (32'(done_nxt) < 32'(thr))) |=> !irq_q);
endmodule

// File: rtl/ring_queue_mgr.sv
module ring_queue_mgr
  import ring_pkg::*;
#(
  parameter int IDX_W     = 14,
  parameter int BIG_IDX_W = 12,
  parameter int THR_W     = 15,
  parameter int RST_SIZE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              exec_done,
  input  logic              exec_irq_req,
  output logic              irq
);
  localparam int CNT_W = IDX_W + 1;

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [CNT_W-1:0] size_eff, done_cnt, done_nxt;
  logic [THR_W-1:0] thr;
  logic [IDX_W-1:0] oldest_idx;
  logic             run, cfg_load, ring_empty, ovf_set, unf_set, comp, rel_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  ring_regs #(.IDX_W(IDX_W), .BIG_IDX_W(BIG_IDX_W), .THR_W(THR_W), .RST_SIZE(RST_SIZE)) regs_i (
    .clk(clk), .rst_n(rst_i_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ring_empty(ring_empty), .ovf_set(ovf_set), .unf_set(unf_set), .done_cnt(done_cnt),
    .oldest_idx(oldest_idx), .size_eff(size_eff), .thr(thr), .run(run), .cfg_load(cfg_load),
    .reg_rdata(reg_rdata));

  ring_tracker #(.IDX_W(IDX_W)) trk_i (
    .clk(clk), .rst_n(rst_i_n), .size_eff(size_eff), .run(run), .cfg_load(cfg_load),
    .add_we(reg_we && (reg_addr == OFF_ADD)), .rel_we(reg_we && (reg_addr == OFF_REL)),
    .wdata(reg_wdata), .desc_ready(desc_ready), .exec_done(exec_done),
    .desc_valid(desc_valid), .desc_idx(desc_idx), .done_cnt(done_cnt), .done_nxt(done_nxt),
    .oldest_idx(oldest_idx), .ring_empty(ring_empty), .ovf_set(ovf_set), .unf_set(unf_set),
    .comp(comp), .rel_acc(rel_acc));

  ring_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) irq_i (
    .clk(clk), .rst_n(rst_i_n), .done_nxt(done_nxt), .thr(thr),
    .comp_req(comp && exec_irq_req), .rel_acc(rel_acc), .irq(irq));

  // R7: the interrupt never stands with nothing done
  assert_irq_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (done_cnt != '0));
  // R3: a stopped block offers nothing
  assert_stop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_we && (reg_addr == OFF_STOP) && (reg_wdata != 32'd0)) |=> !desc_valid);
endmodule

// File: tb/ring_queue_mgr_tb.sv
module ring_queue_mgr_tb_top;
  localparam int IDX_W = 14;
  localparam int NV    = 56;
  localparam int LIMIT = 20000;
  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_X = 3'd2, OP_I = 3'd3, OP_V = 3'd4, OP_Q = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic desc_valid, irq;
  logic desc_ready = 1'b0;
  logic [IDX_W-1:0] desc_idx;
  logic exec_done = 1'b0;
  logic exec_irq_req = 1'b0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ring_queue_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_idx(desc_idx),
    .exec_done(exec_done), .exec_irq_req(exec_irq_req), .irq(irq));

  // {op, offset, data, expected, requirement}
  localparam logic [82:0] VEC [NV] = '{
    {OP_R, 12'h00C, 32'd0,     32'd0,      4'd1},  // R1 done word
    {OP_R, 12'h008, 32'd0,     32'd16,     4'd1},  // R1 size
    {OP_R, 12'h800, 32'd0,     32'd1,      4'd1},  // R1 stopped
    {OP_Q, 12'h000, 32'd0,     32'd0,      4'd1},  // R1 irq low
    {OP_W, 12'h008, 32'd6,     32'd0,      4'd8},  // R8
    {OP_R, 12'h008, 32'd0,     32'd6,      4'd8},
    {OP_W, 12'h808, 32'd4,     32'd0,      4'd2},  // R2
    {OP_V, 12'h000, 32'd0,     32'd0,      4'd3},  // R3 stopped: no offer
    {OP_W, 12'h800, 32'd0,     32'd0,      4'd3},
    {OP_V, 12'h000, 32'd0,     32'd1,      4'd3},
    {OP_X, 12'h000, {16'd6, 16'd4}, 32'd0, 4'd2},  // R2 indices 0..3
    {OP_R, 12'h00C, 32'd0,     32'd4,      4'd5},  // R5
    {OP_Q, 12'h000, 32'd0,     32'd0,      4'd7},
    {OP_W, 12'h804, 32'd3,     32'd0,      4'd6},  // R6
    {OP_R, 12'h00C, 32'd0,     32'h0003_0001, 4'd6},
    {OP_W, 12'h804, 32'd5,     32'd0,      4'd6},
    {OP_R, 12'h00C, 32'd0,     32'h0003_0001, 4'd6},
    {OP_R, 12'h020, 32'd0,     32'd2,      4'd6},
    {OP_W, 12'h020, 32'd2,     32'd0,      4'd6},
    {OP_R, 12'h020, 32'd0,     32'd0,      4'd6},
    {OP_W, 12'h808, 32'd10,    32'd0,      4'd4},  // R4 capped to 5
    {OP_R, 12'h020, 32'd0,     32'd1,      4'd4},
    {OP_X, 12'h000, {16'd6, 16'd5}, 32'd4, 4'd2},  // R2 wrap 4,5,0,1,2
    {OP_R, 12'h00C, 32'd0,     32'h0003_0006, 4'd5},
    {OP_W, 12'h808, 32'd1,     32'd0,      4'd4},  // R4 full ring
    {OP_V, 12'h000, 32'd0,     32'd0,      4'd4},
    {OP_W, 12'h018, 32'd6,     32'd0,      4'd7},  // R7
    {OP_Q, 12'h000, 32'd0,     32'd1,      4'd7},
    {OP_W, 12'h804, 32'd2,     32'd0,      4'd7},
    {OP_Q, 12'h000, 32'd0,     32'd0,      4'd7},
    {OP_R, 12'h00C, 32'd0,     32'h0005_0004, 4'd6},
    {OP_W, 12'h008, 32'd3,     32'd0,      4'd8},  // R8 busy: ignored
    {OP_R, 12'h008, 32'd0,     32'd6,      4'd8},
    {OP_W, 12'h800, 32'd1,     32'd0,      4'd3},
    {OP_W, 12'h808, 32'd1,     32'd0,      4'd3},
    {OP_V, 12'h000, 32'd0,     32'd0,      4'd3},
    {OP_W, 12'h800, 32'd0,     32'd0,      4'd3},
    {OP_I, 12'h000, 32'd0,     32'd3,      4'd7},  // R7 request flag
    {OP_Q, 12'h000, 32'd0,     32'd1,      4'd7},
    {OP_W, 12'h804, 32'd5,     32'd0,      4'd6},
    {OP_Q, 12'h000, 32'd0,     32'd0,      4'd7},
    {OP_R, 12'h00C, 32'd0,     32'h0004_0000, 4'd6},
    {OP_W, 12'h008, 32'd0,     32'd0,      4'd8},
    {OP_R, 12'h008, 32'd0,     32'd1,      4'd8},
    {OP_R, 12'h00C, 32'd0,     32'd0,      4'd8},
    {OP_W, 12'h008, 32'd5000,  32'd0,      4'd8},
    {OP_R, 12'h008, 32'd0,     32'd4096,   4'd8},
    {OP_W, 12'h100, 32'd1,     32'd0,      4'd8},
    {OP_W, 12'h008, 32'd20000, 32'd0,      4'd8},
    {OP_R, 12'h008, 32'd0,     32'd16384,  4'd8},
    {OP_W, 12'h100, 32'd5,     32'd0,      4'd8},
    {OP_R, 12'h100, 32'd0,     32'd1,      4'd8},
    {OP_W, 12'h018, 32'h1FFFF, 32'd0,      4'd9},  // R9
    {OP_R, 12'h018, 32'd0,     32'h7FFF,   4'd9},
    {OP_W, 12'h018, 32'd0,     32'd0,      4'd7},  // R7 zero count
    {OP_Q, 12'h000, 32'd0,     32'd0,      4'd7}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int req);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp, "register read");
  endtask

  task automatic exec_one(input int idx, input bit flag, input int req);
    chk(desc_valid === 1'b1 && 32'(desc_idx) === 32'(idx), req,
        {desc_valid, 31'(desc_idx)}, {1'b1, 31'(idx)}, "issued index");
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0; exec_done = 1'b1; exec_irq_req = flag;
    @(negedge clk);
    exec_done = 1'b0; exec_irq_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      chk(1'b0, 0, 32'(cyc), 32'(LIMIT), "watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [82:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      case (v[82:80])
        OP_W: wr(v[79:68], v[67:36]);
        OP_R: rd(v[79:68], v[35:4], int'(v[3:0]));
        OP_X: for (int i = 0; i < int'(v[51:36]); i++)
                exec_one((int'(v[35:4]) + i) % int'(v[67:52]), 1'b0, int'(v[3:0]));
        OP_I: exec_one(int'(v[35:4]), 1'b1, int'(v[3:0]));
        OP_V: begin
          @(negedge clk); #1;
          chk(desc_valid === v[4], int'(v[3:0]), 32'(desc_valid), v[35:4], "offer state");
        end
        default: begin
          @(negedge clk); #1;
          chk(irq === v[4], int'(v[3:0]), 32'(irq), v[35:4], "interrupt");
        end
      endcase
    end
    // R2/R5/R7: threshold 1, single entry on the large ring
    wr(12'h018, 32'd1);
    wr(12'h808, 32'd1);
    exec_one(0, 1'b0, 2);
    #1;
    chk(irq === 1'b1, 7, 32'(irq), 32'd1, "threshold reached");
    rd(12'h00C, 32'd1, 5);
    // R1: reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(irq === 1'b0, 1, 32'(irq), 32'd0, "irq in reset");
    chk(desc_valid === 1'b0, 1, 32'(desc_valid), 32'd0, "offer in reset");
    rd(12'h008, 32'd16, 1);
    rd(12'h00C, 32'd0, 1);
    rd(12'h100, 32'd7, 1);
    rd(12'h800, 32'd1, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h00C, 32'd0, 1);
    report();
    $finish;
  end
endmodule